// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural registers of a 32-bit processor core: sixteen general registers, a current status word and a saved status word. Several processor modes each own private copies of some general registers. A read or write of register number n lands on whichever physical copy the current mode selects. The current mode is held in the low five bits of the status word.

A mode-switch request carries a target mode code and a save flag. The switch takes effect at the next clock edge. From then on the register numbers map onto the target mode's copies. If the save flag is set, the target mode's saved status register captures the status word as it stood before the switch. If the flag is clear, whatever that mode last held in its saved status register becomes visible again. Two combinational read ports, one write port and direct access to both status words serve the surrounding pipeline.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word is 0x0000005F: mode 0x1F, fast-interrupt disable bit 6 set, all other bits clear. Every register copy reads zero, except three stack registers. The r13 shared by user and system mode is 0x03007F00. The interrupt-mode r13 is 0x03007FA0. The supervisor-mode r13 is 0x03007FE0. The saved status registers are zero.
- R2: The supported mode codes are user 0x10, system 0x1F, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17 and undefined 0x1B. User and system mode see exactly the same sixteen registers.
- R3: Fast-interrupt mode has private r8 to r14. Writes to those register numbers in that mode leave every other mode's view unchanged.
- R4: Interrupt, supervisor, abort and undefined modes each have private r13 and r14. r0 to r12 and r15 are shared with user mode in those four modes.
- R5: A valid switch request changes the status mode field (bits 4:0) at the next clock edge. Reads in the following cycle return the new mode's copies. A register write or a saved-status write issued in the same cycle as the switch goes to the copy selected by the pre-switch mode.
- R6: A switch into a mode that owns a saved status register, with the save flag set, loads that register with the pre-switch status word. With the flag clear, the mode's earlier stored value reappears unchanged.
- R7: A request naming any other mode code changes neither the mode nor any register. It raises sw_err high for exactly the one cycle after the request edge.
- R8: In user and system mode the saved status port reads zero, and saved status writes are ignored.
- R9: A direct status write replaces bits 31:5: flags N, Z, C, V in 31:28, interrupt disable in bit 7, fast-interrupt disable in bit 6 and state in bit 5. It never alters the mode field. Bits 31:5 are kept across mode switches.
- R10: Both read ports are combinational. Each returns, in the cycle after a write, the value written to the register it addresses, including r15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_addr | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| cs_we | input | 1 | Status word write enable |
| cs_wdata | input | 27 | New value for status bits 31:5 |
| cs_q | output | 32 | Current status word |
| ss_we | input | 1 | Saved status write enable |
| ss_wdata | input | 32 | Saved status write data |
| ss_q | output | 32 | Saved status word of the current mode |
| sw_req | input | 1 | Mode switch request |
| sw_mode | input | 5 | Target mode code |
| sw_save | input | 1 | Capture the status word into the target's saved status |
| sw_err | output | 1 | One-cycle pulse for an unsupported mode code |

## Verification
Suppose the bank-select logic maps a register number to the wrong physical copy. The fault does not stay hidden. The first read of that number after the switch, in the very next cycle, shows another mode's value. A write made in one mode then also shows up when the register is read in a mode that should not share it. A lost or misdirected status capture shows on the saved status port as soon as the target mode is entered, or re-entered without the save flag. Giving every register in every mode a distinct written value exposes each such aliasing in the cycle it is read.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32,
  parameter logic [31:0] USR_SP_RST = 32'h0300_7F00,
  parameter logic [31:0] IRQ_SP_RST = 32'h0300_7FA0,
  parameter logic [31:0] SVC_SP_RST = 32'h0300_7FE0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_addr,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cs_we,
  input  logic [DW-1:5] cs_wdata,
  output logic [DW-1:0] cs_q,
  input  logic          ss_we,
  input  logic [DW-1:0] ss_wdata,
  output logic [DW-1:0] ss_q,
  input  logic          sw_req,
  input  logic [4:0]    sw_mode,
  input  logic          sw_save,
  output logic          sw_err
);
  localparam int NREG  = 16;
  localparam int NBANK = 6;
  localparam int NFIQ  = 5;
  localparam logic [2:0] B_USR = 3'd0, B_FIQ = 3'd1, B_IRQ = 3'd2, B_SVC = 3'd3, B_BAD = 3'd7;
  localparam logic [DW-1:0] CS_RST = DW'(32'h0000_005F);

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'h10, 5'h1F: bank_of = B_USR;
      5'h11:        bank_of = B_FIQ;
      5'h12:        bank_of = B_IRQ;
      5'h13:        bank_of = B_SVC;
      5'h17:        bank_of = 3'd4;
      5'h1B:        bank_of = 3'd5;
      default:      bank_of = B_BAD;
    endcase
  endfunction

  logic [DW-1:0] gen [NREG];
  logic [DW-1:0] fq  [NFIQ];
  logic [DW-1:0] bsp [1:NBANK-1];
  logic [DW-1:0] blr [1:NBANK-1];
  logic [DW-1:0] sps [1:NBANK-1];
  logic [DW-1:0] cs;
  logic          err;

  logic [2:0] cur_bank, tgt_bank;
  logic       sw_ok;
  assign cur_bank = bank_of(cs[4:0]);
  assign tgt_bank = bank_of(sw_mode);
  assign sw_ok    = sw_req && (tgt_bank != B_BAD);

  function automatic logic [DW-1:0] view(input logic [3:0] a, input logic [2:0] b);
    if (b == B_FIQ && a >= 4'd8 && a <= 4'd12) view = fq[a[2:0]];
    else if (b != B_USR && a == 4'd13)         view = bsp[b];
    else if (b != B_USR && a == 4'd14)         view = blr[b];
    else                                       view = gen[a];
  endfunction

  always_comb begin
    rd_a_data = view(rd_a_addr, cur_bank);
    rd_b_data = view(rd_b_addr, cur_bank);
    ss_q      = (cur_bank == B_USR) ? '0 : sps[cur_bank];
  end

  assign cs_q   = cs;
  assign sw_err = err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) gen[i] <= '0;
      for (int i = 0; i < NFIQ; i++) fq[i] <= '0;
      for (int i = 1; i < NBANK; i++) begin
        bsp[i] <= '0;
        blr[i] <= '0;
        sps[i] <= '0;
      end
      gen[13]    <= DW'(USR_SP_RST);
      bsp[B_IRQ] <= DW'(IRQ_SP_RST);
      bsp[B_SVC] <= DW'(SVC_SP_RST);
      cs         <= CS_RST;
      err        <= 1'b0;
    end else begin
      err <= sw_req && (tgt_bank == B_BAD);
      if (wr_en) begin
        if (cur_bank == B_FIQ && wr_addr >= 4'd8 && wr_addr <= 4'd12) fq[wr_addr[2:0]] <= wr_data;
        else if (cur_bank != B_USR && wr_addr == 4'd13) bsp[cur_bank] <= wr_data;
        else if (cur_bank != B_USR && wr_addr == 4'd14) blr[cur_bank] <= wr_data;
        else gen[wr_addr] <= wr_data;
      end
      if (cs_we) cs[DW-1:5] <= cs_wdata;
      if (ss_we && cur_bank != B_USR) sps[cur_bank] <= ss_wdata;
      if (sw_ok) begin
        cs[4:0] <= sw_mode;
        if (sw_save && tgt_bank != B_USR) sps[tgt_bank] <= cs;
      end
    end
  end

  assert_mode_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_of(cs_q[4:0]) != B_BAD);
  assert_switch_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ok |=> cs_q[4:0] == $past(sw_mode));
  assert_save_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ok && sw_save && tgt_bank != B_USR) |=> ss_q == $past(cs_q));
  assert_bad_mode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_err |-> cs_q[4:0] == $past(cs_q[4:0]));
  assert_user_ss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q[4:0] == 5'h10 || cs_q[4:0] == 5'h1F) |-> ss_q == '0);
  assert_flags_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_we |=> $stable(cs_q[DW-1:5]));
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] MODES [7] = '{5'h10, 5'h1F, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};

  logic        clk = 0, rst_n = 0;
  logic [3:0]  rd_a_addr = 0, rd_b_addr = 0, wr_addr = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, cs_q, ss_q, ss_wdata = 0;
  logic        wr_en = 0, cs_we = 0, ss_we = 0, sw_req = 0, sw_save = 0, sw_err;
  logic [31:5] cs_wdata = 0;
  logic [4:0]  sw_mode = 0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile u0 (.clk(clk), .rst_n(rst_n), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cs_we(cs_we), .cs_wdata(cs_wdata), .cs_q(cs_q), .ss_we(ss_we),
    .ss_wdata(ss_wdata), .ss_q(ss_q), .sw_req(sw_req), .sw_mode(sw_mode), .sw_save(sw_save),
    .sw_err(sw_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic switch_to(input logic [4:0] m, input logic save);
    sw_req = 1; sw_mode = m; sw_save = save;
    tick();
    sw_req = 0; sw_save = 0;
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic read_both(input string tag, input logic [3:0] a, input logic [31:0] exp);
    rd_a_addr = a; rd_b_addr = a;
    #1;
    chk({tag, " port A"}, rd_a_data, exp);
    chk({tag, " port B"}, rd_b_data, exp);
  endtask

  function automatic logic [31:0] pat(input logic [4:0] m, input logic [3:0] a);
    return 32'hA000_0000 | (32'(m) << 8) | 32'(a);
  endfunction

  function automatic logic [31:0] rst_val(input logic [4:0] m, input logic [3:0] a);
    if (a != 4'd13) return 32'h0;
    if (m == 5'h10 || m == 5'h1F) return 32'h0300_7F00;
    if (m == 5'h12) return 32'h0300_7FA0;
    if (m == 5'h13) return 32'h0300_7FE0;
    return 32'h0;
  endfunction

  function automatic logic [31:0] swept_val(input logic [4:0] m, input logic [3:0] a);
    if (a >= 4'd8 && a <= 4'd12) return (m == 5'h11) ? pat(5'h11, a) : pat(5'h1B, a);
    if (a == 4'd13 || a == 4'd14) return (m == 5'h1F) ? pat(5'h10, a) : pat(m, a);
    return pat(5'h1B, a);
  endfunction

  function automatic bit supported(input logic [4:0] m);
    foreach (MODES[i]) if (MODES[i] == m) return 1;
    return 0;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    rst_n = 1;
    tick();
    chk("R1 reset status", cs_q, 32'h0000_005F);
    chk("R1 reset err", 32'(sw_err), 0);

    // R1 R2 R4: reset contents seen from every mode
    foreach (MODES[i]) begin
      switch_to(MODES[i], 0);
      chk("R5 mode field", 32'(cs_q[4:0]), 32'(MODES[i]));
      chk("R1 reset saved status", ss_q, 0);
      for (int a = 0; a < 16; a++) read_both("R1 reset reg", 4'(a), rst_val(MODES[i], 4'(a)));
    end

    // R3 R4 R10: distinct pattern in every mode except system
    foreach (MODES[i]) begin
      if (MODES[i] == 5'h1F) continue;
      switch_to(MODES[i], 0);
      for (int a = 0; a < 16; a++) begin
        write_reg(4'(a), pat(MODES[i], 4'(a)));
        read_both("R10 readback", 4'(a), pat(MODES[i], 4'(a)));
      end
    end
    foreach (MODES[i]) begin
      switch_to(MODES[i], 0);
      for (int a = 0; a < 16; a++) read_both("R2 R3 R4 bank view", 4'(a), swept_val(MODES[i], 4'(a)));
    end

    // R5: write in the switch cycle goes to the old mapping
    switch_to(5'h10, 0);
    wr_en = 1; wr_addr = 4'd13; wr_data = 32'h5555_0013;
    sw_req = 1; sw_mode = 5'h12;
    tick();
    wr_en = 0; sw_req = 0;
    read_both("R5 new mapping next cycle", 4'd13, pat(5'h12, 4'd13));
    switch_to(5'h10, 0);
    read_both("R5 old mapping got write", 4'd13, 32'h5555_0013);

    // R9: status write keeps the mode field
    cs_we = 1; cs_wdata = 27'(32'h9000_00A0 >> 5);
    tick();
    cs_we = 0;
    chk("R9 status write", cs_q, 32'h9000_00B0);
    cs_we = 1; cs_wdata = '1;
    tick();
    cs_we = 0;
    chk("R9 mode untouched", cs_q, 32'hFFFF_FFF0);
    cs_we = 1; cs_wdata = 27'(32'h9000_00A0 >> 5);
    tick();
    cs_we = 0;

    // R6: save capture and restore
    switch_to(5'h12, 1);
    chk("R6 captured", ss_q, 32'h9000_00B0);
    chk("R9 flags kept across switch", cs_q, 32'h9000_00B2);
    ss_we = 1; ss_wdata = 32'h1234_5678;
    tick();
    ss_we = 0;
    chk("R6 saved write", ss_q, 32'h1234_5678);
    switch_to(5'h13, 0);
    chk("R6 other mode stored", ss_q, 0);
    switch_to(5'h12, 0);
    chk("R6 restored", ss_q, 32'h1234_5678);
    ss_we = 1; ss_wdata = 32'h0000_CAFE; sw_req = 1; sw_mode = 5'h13;
    tick();
    ss_we = 0; sw_req = 0;
    chk("R5 saved write old mapping", ss_q, 0);
    switch_to(5'h12, 0);
    chk("R5 saved write landed", ss_q, 32'h0000_CAFE);

    // R8: user/system saved status
    switch_to(5'h10, 1);
    chk("R8 user reads zero", ss_q, 0);
    ss_we = 1; ss_wdata = 32'hDEAD_BEEF;
    tick();
    ss_we = 0;
    chk("R8 user write ignored", ss_q, 0);
    switch_to(5'h1F, 0);
    chk("R8 system reads zero", ss_q, 0);
    switch_to(5'h12, 0);
    chk("R8 user write no effect", ss_q, 32'h0000_CAFE);

    // R7: every unsupported code
    for (int c = 0; c < 32; c++) begin
      if (supported(5'(c))) continue;
      switch_to(5'(c), 1);
      chk("R7 err pulse", 32'(sw_err), 1);
      chk("R7 mode held", cs_q, 32'h9000_00B2);
      chk("R7 saved held", ss_q, 32'h0000_CAFE);
      tick();
      chk("R7 err one cycle", 32'(sw_err), 0);
    end
    read_both("R7 regs held", 4'd13, pat(5'h12, 4'd13));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule